// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter

This block sits behind a serial ARINC 429 receiver front end. When the front end strobes `eos`, the block takes the completed 32-bit word. It replaces bit 32 with a parity-error flag. It then decides whether the word is kept, using two filters that are enabled independently. The label filter looks up the word's label in a 256-entry enable bitmap that the host loads. The decoder filter compares bits 9 and 10 against two control bits. Kept words go into a 32-deep by 32-bit receive FIFO, and the host pops them through a read port with empty, half-full and full status.

ARINC bit n is held in `rx_word[n-1]`. The label is bits 1 to 8 (`rx_word[7:0]`). The decoder bits are bit 9 (`rx_word[8]`) and bit 10 (`rx_word[9]`). The parity flag is bit 32 (`rx_word[31]`). The filter controls are sampled in the same cycle as `eos`.

A two-state machine sequences the work:
- **ST_WAIT** (the reset state) waits for `eos`. On `eos` it registers the flagged word and the keep/drop verdict, then takes the transition **capture** to ST_JUDGE.
- **ST_JUDGE** pushes the held word into the FIFO if the verdict was keep. It takes the transition **release** back to ST_WAIT. If another `eos` arrives in this cycle, it instead takes the transition **recapture**: it registers the new word and stays in ST_JUDGE.

A kept word becomes visible at the read port after the second rising edge that follows the `eos` cycle.

Top module: `arx_word_filter`

## Requirements
- R1: A word enters the FIFO only after an `eos` strobe. A word held on `rx_word` without `eos` never reaches the FIFO. A word that is kept is visible at the read port (empty low) after the second rising edge that follows the `eos` cycle.
- R2: The stored bit 32 (`rd_data[31]`) is 0 when the received 32 bits have odd parity and 1 when they have even parity. Stored bits 1 to 31 equal the received bits.
- R3: A word with even parity is still stored when it passes the filters.
- R4: With `lbl_en`=0, the label has no effect on whether a word is stored.
- R5: With `lbl_en`=1, a word is stored only if bitmap entry `rx_word[7:0]` is 1. The host writes entry `map_addr` with `map_bit` when `map_we` is high. Reset clears every entry to 0.
- R6: With `dec_en`=0, bits 9 and 10 have no effect on whether a word is stored.
- R7: With `dec_en`=1, a word is stored only if `rx_word[8]`==`dec_b9` and `rx_word[9]`==`dec_b10`.
- R8: With both filters enabled, a word is stored only if it passes both checks.
- R9: The FIFO holds 32 words. `rd_data` shows the oldest word, and an `rd_en` cycle pops that word, so words come out in arrival order.
- R10: `empty` is high at 0 words, `half_full` is high at 16 or more words, and `full` is high at 32 words.
- R11: A kept word that arrives while the FIFO is full is dropped and sets `overflow`. Reading the FIFO does not clear `overflow`; only `ovf_clr` does.
- R12: An `rd_en` cycle while the FIFO is empty changes nothing. The next word stored is the next word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| eos | input | 1 | Strobe: a completed word is on `rx_word` |
| rx_word | input | 32 | Received word, ARINC bit n in position n-1 |
| lbl_en | input | 1 | Enable the label filter |
| dec_en | input | 1 | Enable the bits-9/10 filter |
| dec_b9 | input | 1 | Required value of bit 9 |
| dec_b10 | input | 1 | Required value of bit 10 |
| map_we | input | 1 | Label bitmap write enable |
| map_addr | input | 8 | Label bitmap entry to write |
| map_bit | input | 1 | Value written to the bitmap entry |
| rd_en | input | 1 | Pop the oldest FIFO word |
| ovf_clr | input | 1 | Clear the overflow flag |
| rd_data | output | 32 | Oldest FIFO word |
| empty | output | 1 | FIFO holds no words |
| half_full | output | 1 | FIFO holds 16 or more words |
| full | output | 1 | FIFO holds 32 words |
| overflow | output | 1 | Sticky flag: a kept word was lost |

## Verification
The assertions check these rules on every cycle:
- The FIFO is never full and empty at once.
- A push into a full FIFO raises `overflow`, and `overflow` stays set until `ovf_clr`.
- A pop from an empty FIFO leaves it empty.
- A push only happens the cycle after an `eos`, and it carries the received bits 1 to 31 unchanged.

The bench's scenarios show the behaviour that depends on data:
- that the parity flag is computed correctly;
- the keep/drop verdict for each combination of filter enables, labels and bits 9/10;
- arrival order through a full FIFO;
- the half-full threshold.

// File: rtl/arx_pkg.sv
package arx_pkg;
    localparam int WORD_W  = 32;
    localparam int LABEL_W = 8;

    typedef enum logic [0:0] {
        ST_WAIT  = 1'b0,
        ST_JUDGE = 1'b1
    } arx_state_e;
endpackage

// File: rtl/arx_label_map.sv
module arx_label_map #(
    parameter int LABEL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [LABEL_W-1:0] waddr,
    input  logic               wbit,
    input  logic [LABEL_W-1:0] raddr,
    output logic               hit
);
    localparam int ENTRIES = 1 << LABEL_W;

    logic [ENTRIES-1:0] bitmap;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bitmap[i] <= 1'b0;
            else if (we && (waddr == LABEL_W'(i)))
                bitmap[i] <= wbit;
        end
    end

    assign hit = bitmap[raddr];
endmodule

// File: rtl/arx_word_check.sv
module arx_word_check #(
    parameter int WORD_W = 32
) (
    input  logic              map_hit,
    input  logic [WORD_W-1:0] word_in,
    input  logic              lbl_en,
    input  logic              dec_en,
    input  logic              dec_b9,
    input  logic              dec_b10,
    output logic [WORD_W-1:0] word_out,
    output logic              keep
);
    logic odd_ok;
    logic lbl_ok;
    logic dec_ok;

    always_comb begin
        odd_ok   = ^word_in;
        word_out = {~odd_ok, word_in[WORD_W-2:0]};
        lbl_ok   = !lbl_en || map_hit;
        dec_ok   = !dec_en || ((word_in[8] == dec_b9) && (word_in[9] == dec_b10));
        keep     = lbl_ok && dec_ok;
    end
endmodule

// File: rtl/arx_rx_fifo.sv
module arx_rx_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    input  logic              ovf_clr,
    output logic [WORD_W-1:0] head,
    output logic              empty,
    output logic              half_full,
    output logic              full,
    output logic              overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic              do_wr;
    logic              do_rd;

    always_comb begin
        empty     = (count == '0);
        full      = (count == CW'(DEPTH));
        half_full = (count >= CW'(DEPTH / 2));
        do_wr     = push && !full;
        do_rd     = pop && !empty;
        head      = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_wr)
                wr_ptr <= wr_ptr + 1'b1;
            if (do_rd)
                rd_ptr <= rd_ptr + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full)
                overflow <= 1'b1;
            else if (ovf_clr)
                overflow <= 1'b0;
        end
    end

    a_r10_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    a_r11_ovf_on_full_push: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> overflow);
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);
    a_r12_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/arx_word_filter.sv
module arx_word_filter #(
    parameter int WORD_W  = arx_pkg::WORD_W,
    parameter int LABEL_W = arx_pkg::LABEL_W,
    parameter int DEPTH   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eos,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              lbl_en,
    input  logic              dec_en,
    input  logic              dec_b9,
    input  logic              dec_b10,
    input  logic              map_we,
    input  logic [LABEL_W-1:0] map_addr,
    input  logic              map_bit,
    input  logic              rd_en,
    input  logic              ovf_clr,
    output logic [WORD_W-1:0] rd_data,
    output logic              empty,
    output logic              half_full,
    output logic              full,
    output logic              overflow
);
    import arx_pkg::*;

    arx_state_e        state_q;
    arx_state_e        state_d;
    logic [WORD_W-1:0] chk_word;
    logic              chk_keep;
    logic              map_hit;
    logic [WORD_W-1:0] held_word;
    logic              held_keep;
    logic              fifo_push;

    arx_label_map #(.LABEL_W(LABEL_W)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (map_we),
        .waddr (map_addr),
        .wbit  (map_bit),
        .raddr (rx_word[LABEL_W-1:0]),
        .hit   (map_hit)
    );

    arx_word_check #(.WORD_W(WORD_W)) u_chk (
        .map_hit  (map_hit),
        .word_in  (rx_word),
        .lbl_en   (lbl_en),
        .dec_en   (dec_en),
        .dec_b9   (dec_b9),
        .dec_b10  (dec_b10),
        .word_out (chk_word),
        .keep     (chk_keep)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_WAIT;
            held_word <= '0;
            held_keep <= 1'b0;
        end else begin
            state_q <= state_d;
            if (eos) begin
                held_word <= chk_word;
                held_keep <= chk_keep;
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        fifo_push = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (eos)
                    state_d = ST_JUDGE;
            end
            ST_JUDGE: begin
                fifo_push = held_keep;
                state_d   = eos ? ST_JUDGE : ST_WAIT;
            end
            default: state_d = ST_WAIT;
        endcase
    end

    arx_rx_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (held_word),
        .pop       (rd_en),
        .ovf_clr   (ovf_clr),
        .head      (rd_data),
        .empty     (empty),
        .half_full (half_full),
        .full      (full),
        .overflow  (overflow)
    );

    a_r1_push_after_eos: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> $past(eos));
    a_r2_body_kept: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (held_word[WORD_W-2:0] == $past(rx_word[WORD_W-2:0])));
endmodule

// File: tb/sim_arx_word_filter.sv
module sim_arx_word_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eos = 1'b0;
    logic [31:0] rx_word = '0;
    logic        lbl_en = 1'b0;
    logic        dec_en = 1'b0;
    logic        dec_b9 = 1'b0;
    logic        dec_b10 = 1'b0;
    logic        map_we = 1'b0;
    logic [7:0]  map_addr = '0;
    logic        map_bit = 1'b0;
    logic        rd_en = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [31:0] rd_data;
    logic        empty;
    logic        half_full;
    logic        full;
    logic        overflow;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    arx_word_filter u0 (
        .clk(clk), .rst_n(rst_n), .eos(eos), .rx_word(rx_word),
        .lbl_en(lbl_en), .dec_en(dec_en), .dec_b9(dec_b9), .dec_b10(dec_b10),
        .map_we(map_we), .map_addr(map_addr), .map_bit(map_bit),
        .rd_en(rd_en), .ovf_clr(ovf_clr), .rd_data(rd_data),
        .empty(empty), .half_full(half_full), .full(full), .overflow(overflow)
    );

    typedef struct packed {
        logic [31:0] w;
        logic        le;
        logic        de;
        logic        b9;
        logic        b10;
        logic        keep;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h1234_5611, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'h1234_5711, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'h0ABC_003A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'h0ABC_0011, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{32'h0000_0155, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{32'h0000_0255, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h0000_01C5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        '{32'h0000_02C5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h0000_0111, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h7000_0311, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{32'h0000_0399, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    function automatic logic [31:0] flagged(input logic [31:0] w);
        return {~(^w), w[30:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic map_write(input logic [7:0] a, input logic v);
        @(negedge clk);
        map_we = 1'b1; map_addr = a; map_bit = v;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] w, input logic le, input logic de,
                        input logic b9, input logic b10);
        @(negedge clk);
        eos = 1'b1; rx_word = w; lbl_en = le; dec_en = de; dec_b9 = b9; dec_b10 = b10;
        @(negedge clk);
        eos = 1'b0;
        @(negedge clk);
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset empty", 32'(empty), 32'd1);
        check("R10 reset full", 32'(full), 32'd0);
        check("R10 reset half", 32'(half_full), 32'd0);
        check("R11 reset overflow", 32'(overflow), 32'd0);

        // R5: bitmap reset to zero, so an enabled label filter drops this word
        send(32'h0000_003A, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R5 bitmap cleared by reset", 32'(empty), 32'd1);

        // R1: word present without eos is never stored
        @(negedge clk);
        rx_word = 32'hDEAD_BEEF;
        repeat (4) @(negedge clk);
        check("R1 no eos no store", 32'(empty), 32'd1);

        map_write(8'h3A, 1'b1);
        map_write(8'hC5, 1'b1);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            send(VECS[i].w, VECS[i].le, VECS[i].de, VECS[i].b9, VECS[i].b10);
            check($sformatf("R4-8 vec%0d stored", i), 32'(!empty), 32'(VECS[i].keep));
            if (VECS[i].keep && !empty) begin
                check($sformatf("R2 R3 vec%0d data", i), rd_data, flagged(VECS[i].w));
                pop();
            end
            check($sformatf("R9 vec%0d drained", i), 32'(empty), 32'd1);
        end

        // R5: clearing a bitmap entry disables its label
        map_write(8'h3A, 1'b0);
        send(32'h0ABC_003A, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R5 label disabled by write", 32'(empty), 32'd1);

        // R12: read while empty ignored
        @(negedge clk);
        pop();
        check("R12 empty after empty read", 32'(empty), 32'd1);
        send(32'h0000_0A01, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R12 next word read", rd_data, flagged(32'h0000_0A01));
        pop();

        // R9 R10 R11: fill, overflow, drain in order
        for (int i = 0; i < 32; i++) begin
            send(32'h0001_0000 * i + 32'h40, 1'b0, 1'b0, 1'b0, 1'b0);
            if (i == 14) check("R10 half low at 15", 32'(half_full), 32'd0);
            if (i == 15) check("R10 half high at 16", 32'(half_full), 32'd1);
            if (i == 30) check("R10 not full at 31", 32'(full), 32'd0);
        end
        check("R10 full at 32", 32'(full), 32'd1);
        check("R11 no overflow yet", 32'(overflow), 32'd0);
        send(32'h5555_0077, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R11 overflow set", 32'(overflow), 32'd1);
        for (int i = 0; i < 32; i++) begin
            check($sformatf("R9 order %0d", i), rd_data, flagged(32'h0001_0000 * i + 32'h40));
            pop();
        end
        check("R9 empty after drain", 32'(empty), 32'd1);
        check("R11 overflow sticky after reads", 32'(overflow), 32'd1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check("R11 overflow cleared", 32'(overflow), 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule